// File: doc/BRIEF.md
# Sleep-Gated SPI Register Slave

This block is the serial register port of a low-power device. A host reaches the core's registers through a four-wire SPI link in mode 0. Each frame has 16 bits: a direction bit, a 7-bit register address, and 8 data bits, all sent MSB first. The block drives a simple strobe interface toward the core. Writes are handed over with a single-cycle write strobe. Read data is fetched at the end of the header and shifted back during the data byte.

When the device sleeps, its internal oscillator is stopped. A falling chip select in sleep starts a settling window. The window is counted on the free-running reference clock and stands in for the oscillator start-up time. During the window, serial clock edges are dropped and the data output is not enabled. After the window, the same chip-select period carries transfers at the full serial rate. Sleep access needs the I/O supply flag. Without it, nothing on the link is accepted. Outside sleep, no window applies.

All link pins are oversampled through two-stage synchronizers. The reference clock must therefore run at several times the serial clock rate: a 50 MHz reference supports a serial clock of about 4 MHz.

Top module: `spi_sleep_slave`

## Requirements
- R1: After reset, `spi_miso_en`, `reg_we`, `reg_re` and `wake_pend` are all 0.
- R2: A frame is 16 bits, sampled on rising SCLK and sent MSB first. Bit 15 selects the direction (0 = write, 1 = read), bits 14..8 carry the address and bits 7..0 the data. A write frame produces exactly one `reg_we` with that address and data.
- R3: On a read frame, `reg_re` is issued with the address once the 8th rising edge is taken. The `reg_rdata` value from that cycle then appears on `spi_miso`, MSB first, for the host to sample on rising edges 9 to 16.
- R4: A frame closed by chip select before its 16th rising edge writes nothing. Edges beyond the 16th within one chip-select period cause no further access.
- R5: While `sleep_mode` is 0, `wake_pend` stays 0 and a frame that starts right after chip select falls is fully accepted.
- R6: In sleep with `io_supply_ok` high, a falling chip select raises `wake_pend` for exactly `WAKE_CYC` reference cycles. Rising SCLK edges in that window shift nothing, and `spi_miso_en` stays 0.
- R7: Once the window ends, with chip select still low, a full-rate frame is accepted exactly as in the awake case.
- R8: If chip select rises during the window, the window is cancelled and nothing is written. The next falling edge in sleep starts a full new window.
- R9: In sleep with `io_supply_ok` low, no window starts, `spi_miso_en` stays 0 and no `reg_we` or `reg_re` is issued.
- R10: `spi_miso_en` is 1 only while chip select is low and the gate is open. It is 0 while chip select is high.
- R11: `reg_we` and `reg_re` are never high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_csn | input | 1 | Chip select, active low |
| spi_sclk | input | 1 | Serial clock, mode 0 |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| spi_miso_en | output | 1 | Output enable for `spi_miso` |
| sleep_mode | input | 1 | Device is in sleep; oscillator is stopped |
| io_supply_ok | input | 1 | I/O supply present |
| wake_pend | output | 1 | Oscillator settling window active |
| reg_addr | output | ADDR_W | Register address toward core |
| reg_wdata | output | DATA_W | Write data toward core |
| reg_we | output | 1 | Single-cycle write strobe |
| reg_re | output | 1 | Single-cycle read strobe |
| reg_rdata | input | DATA_W | Read data from core, valid in the `reg_re` cycle |

## Verification
If the bit counter slips by one edge, the error shows on the next strobe. That happens within one frame, as a shifted address or data byte on `reg_we`, or as wrong read data on `spi_miso`. A settling counter that ends too early or too late changes the number of cycles `wake_pend` is high, so it is caught to the cycle. A late stray edge placed just inside the window would also misalign the frame that follows. A gate that opens when it should stay shut shows either as an unexpected strobe or as `spi_miso_en` going high within a few reference cycles of chip select falling in sleep.

// File: rtl/spi_wake_pkg.sv
// Shared types for the sleep-gated SPI slave.
// Assumes: a frame opens with one direction bit, then address, then data.
package spi_wake_pkg;
    typedef enum logic {
        ACC_WRITE = 1'b0,
        ACC_READ  = 1'b1
    } acc_e;
endpackage

// File: rtl/spi_in_sync.sv
// Two-stage synchronizer bank for asynchronous link pins.
// Assumes: the reference clock runs several times faster than any pin toggles.
// Reset loads RST_VAL so that chip select starts out inactive.
module spi_in_sync #(
    parameter int              W       = 3,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] meta;

    for (genvar i = 0; i < W; i++) begin : g_bit
        // Two flops per pin to settle metastability.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta[i] <= RST_VAL[i];
                dout[i] <= RST_VAL[i];
            end else begin
                meta[i] <= din[i];
                dout[i] <= meta[i];
            end
        end
    end
endmodule

// File: rtl/spi_wake_gate.sv
// Decides whether serial clock edges may be used.
// In sleep with the I/O supply present, a chip-select fall starts a settling
// window of WAKE_CYC reference cycles. In sleep without the supply, the whole
// chip-select period is blocked. Outside sleep, the gate opens at once.
// Assumes: cs_low_now and cs_low_prev are synchronized and one cycle apart.
module spi_wake_gate #(
    parameter int WAKE_CYC = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_low_now,
    input  logic cs_low_prev,
    input  logic sleep_mode,
    input  logic io_supply_ok,
    output logic busy,
    output logic gate_open
);
    localparam int CNT_W = $clog2(WAKE_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(WAKE_CYC);

    logic [CNT_W-1:0] cnt;
    logic             blocked;
    logic             cs_fall, cs_rise, no_supply;

    assign cs_fall   = cs_low_now & ~cs_low_prev;
    assign cs_rise   = ~cs_low_now & cs_low_prev;
    assign no_supply = sleep_mode & ~io_supply_ok;
    assign busy      = (cnt != '0);
    assign gate_open = cs_low_prev & ~busy & ~blocked & ~no_supply;

    // Settling counter and supply block, both cleared when chip select rises.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            blocked <= 1'b0;
        end else if (cs_rise) begin
            cnt     <= '0;
            blocked <= 1'b0;
        end else if (cs_fall) begin
            cnt     <= (sleep_mode && io_supply_ok) ? CNT_LOAD : '0;
            blocked <= no_supply;
        end else if (busy) begin
            cnt <= cnt - 1'b1;
        end
    end

    assert_window_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_fall && sleep_mode && io_supply_ok) |=> busy);
    assert_count_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_LOAD);
    assert_abort_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cs_rise |=> !busy);
endmodule

// File: rtl/spi_frame_engine.sv
// Frame decoder and register strobe driver.
// Shifts host bits on gated rising edges. Issues the read strobe after the
// header and the write strobe after the last data bit. Shifts read data out
// on falling edges during the data byte.
// Assumes: the core returns reg_rdata combinationally from reg_addr in the
// reg_re cycle; DATA_W >= 2 and ADDR_W >= 1.
module spi_frame_engine
    import spi_wake_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_low,
    input  logic              gate_open,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic              mosi,
    output logic              miso,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              reg_we,
    output logic              reg_re,
    input  logic [DATA_W-1:0] reg_rdata
);
    localparam int HDR   = 1 + ADDR_W;
    localparam int FRAME = HDR + DATA_W;
    localparam int CW    = $clog2(FRAME + 1);
    localparam int SR_W  = ((HDR > DATA_W) ? HDR : DATA_W) - 1;
    localparam logic [CW-1:0] CNT_HDR   = CW'(HDR);
    localparam logic [CW-1:0] CNT_FRAME = CW'(FRAME);
    localparam logic [CW-1:0] LAST_HDR  = CW'(HDR - 1);
    localparam logic [CW-1:0] LAST_BIT  = CW'(FRAME - 1);

    logic [CW-1:0]     bitcnt;
    logic [SR_W-1:0]   rx_sr;
    logic [DATA_W-1:0] tx_sr;
    logic [HDR-1:0]    hdr;
    logic [DATA_W-1:0] dat;
    acc_e              rw_q;
    logic              shift_en, out_shift;

    assign hdr       = {rx_sr[HDR-2:0], mosi};
    assign dat       = {rx_sr[DATA_W-2:0], mosi};
    assign shift_en  = gate_open && sclk_rise && (bitcnt < CNT_FRAME);
    assign out_shift = gate_open && sclk_fall && (bitcnt > CNT_HDR);
    assign miso      = (rw_q == ACC_READ && bitcnt >= CNT_HDR) ? tx_sr[DATA_W-1] : 1'b0;

    // Input shifting, header capture and strobe generation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bitcnt    <= '0;
            rx_sr     <= '0;
            rw_q      <= ACC_WRITE;
            reg_addr  <= '0;
            reg_wdata <= '0;
            reg_we    <= 1'b0;
            reg_re    <= 1'b0;
        end else if (!cs_low) begin
            bitcnt <= '0;
            reg_we <= 1'b0;
            reg_re <= 1'b0;
        end else begin
            reg_we <= 1'b0;
            reg_re <= 1'b0;
            if (shift_en) begin
                rx_sr  <= {rx_sr[SR_W-2:0], mosi};
                bitcnt <= bitcnt + 1'b1;
                if (bitcnt == LAST_HDR) begin
                    rw_q     <= acc_e'(hdr[HDR-1]);
                    reg_addr <= hdr[ADDR_W-1:0];
                    reg_re   <= hdr[HDR-1];
                end
                if (bitcnt == LAST_BIT && rw_q == ACC_WRITE) begin
                    reg_wdata <= dat;
                    reg_we    <= 1'b1;
                end
            end
        end
    end

    // Read data load on the read strobe, then MSB-first shift on falling edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sr <= '0;
        end else if (reg_re) begin
            tx_sr <= reg_rdata;
        end else if (cs_low && out_shift) begin
            tx_sr <= {tx_sr[DATA_W-2:0], 1'b0};
        end
    end

    assert_we_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we);
    assert_re_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        reg_re |=> !reg_re);
    assert_idle_reset_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_low |=> (bitcnt == '0));
endmodule

// File: rtl/spi_sleep_slave.sv
// Top level: SPI mode-0 register slave with sleep wake-up gating.
// Synchronizes the link pins, detects edges, gates them through the wake
// window and decodes frames into register strobes.
// Assumes: clk is free-running and at least about 12x the serial clock rate.
module spi_sleep_slave #(
    parameter int ADDR_W   = 7,
    parameter int DATA_W   = 8,
    parameter int WAKE_CYC = 500
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_csn,
    input  logic              spi_sclk,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic              spi_miso_en,
    input  logic              sleep_mode,
    input  logic              io_supply_ok,
    output logic              wake_pend,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              reg_we,
    output logic              reg_re,
    input  logic [DATA_W-1:0] reg_rdata
);
    localparam int SYNC_W = 3;
    localparam logic [SYNC_W-1:0] SYNC_RST = 3'b001;

    logic [SYNC_W-1:0] pins_s;
    logic [1:0]        pins_q;
    logic              cs_low_now, cs_low_prev, sclk_rise, sclk_fall;
    logic              gate_open, miso_raw;

    spi_in_sync #(.W(SYNC_W), .RST_VAL(SYNC_RST)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({spi_mosi, spi_sclk, spi_csn}),
        .dout (pins_s)
    );

    // One-cycle delay of chip select and clock for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) pins_q <= 2'b01;
        else        pins_q <= pins_s[1:0];
    end

    assign cs_low_now  = ~pins_s[0];
    assign cs_low_prev = ~pins_q[0];
    assign sclk_rise   = pins_s[1] & ~pins_q[1];
    assign sclk_fall   = ~pins_s[1] & pins_q[1];

    spi_wake_gate #(.WAKE_CYC(WAKE_CYC)) u_gate (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_low_now  (cs_low_now),
        .cs_low_prev (cs_low_prev),
        .sleep_mode  (sleep_mode),
        .io_supply_ok(io_supply_ok),
        .busy        (wake_pend),
        .gate_open   (gate_open)
    );

    spi_frame_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_low   (cs_low_prev),
        .gate_open(gate_open),
        .sclk_rise(sclk_rise),
        .sclk_fall(sclk_fall),
        .mosi     (pins_s[2]),
        .miso     (miso_raw),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .reg_we   (reg_we),
        .reg_re   (reg_re),
        .reg_rdata(reg_rdata)
    );

    assign spi_miso_en = gate_open;
    assign spi_miso    = gate_open & miso_raw;

    assert_no_supply_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_mode && !io_supply_ok) |-> !spi_miso_en);
    assert_window_hides_out_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pend |-> !spi_miso_en);
endmodule

// File: tb/spi_sleep_slave_test.sv
module spi_sleep_slave_test;
    localparam int WAKE = 500;
    localparam int HALF = 126;

    logic clk = 0, rst_n = 0;
    logic csn = 1, sclk = 0, mosi = 0, sleep_mode = 0, vio = 1;
    logic miso, miso_en, wake_pend, reg_we, reg_re;
    logic [6:0] reg_addr;
    logic [7:0] reg_wdata, reg_rdata;

    int checks = 0, errors = 0, cyc = 0;
    int we_total = 0, re_total = 0, wp_total = 0, viol = 0;
    logic [6:0] we_addr = 0;
    logic [7:0] we_data = 0;
    logic prev_we = 0, prev_re = 0;

    assign reg_rdata = {reg_addr, 1'b0} ^ 8'hA5;

    spi_sleep_slave #(.ADDR_W(7), .DATA_W(8), .WAKE_CYC(WAKE)) uut (
        .clk(clk), .rst_n(rst_n), .spi_csn(csn), .spi_sclk(sclk), .spi_mosi(mosi),
        .spi_miso(miso), .spi_miso_en(miso_en), .sleep_mode(sleep_mode),
        .io_supply_ok(vio), .wake_pend(wake_pend), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_re(reg_re), .reg_rdata(reg_rdata)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Port monitor: strobe counts, last write, pulse widths, window length.
    always @(negedge clk) begin
        if (rst_n) begin
            if (reg_we) begin we_total <= we_total + 1; we_addr <= reg_addr; we_data <= reg_wdata; end
            if (reg_re) re_total <= re_total + 1;
            if ((reg_we && prev_we) || (reg_re && prev_re)) viol <= viol + 1;
            if (wake_pend) wp_total <= wp_total + 1;
            prev_we <= reg_we;
            prev_re <= reg_re;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cs_drive(input logic v);
        @(negedge clk); #5; csn = v; #HALF;
    endtask

    // Clocks n bits of pat (MSB first); captures miso before rising edges 9..16.
    task automatic spi_bits(input int n, input logic [31:0] pat, output logic [7:0] rd);
        rd = 0;
        for (int i = 0; i < n; i++) begin
            mosi = pat[n-1-i];
            #HALF;
            if (i >= 8 && i < 16) rd[15-i] = miso;
            sclk = 1; #HALF; sclk = 0;
        end
    endtask

    task automatic frame(input int n, input logic [31:0] pat, output logic [7:0] rd);
        cs_drive(0);
        spi_bits(n, pat, rd);
        cs_drive(1);
        wait_cyc(8);
    endtask

    initial begin
        #(190000 * 20);
        errors++;
        $display("FAIL watchdog actual %0d expected %0d", cyc, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] rd;
        int w0, r0, p0, t0;
        wait_cyc(4);
        rst_n = 1;
        wait_cyc(2);
        // R1 reset state
        chk(miso_en == 0 && reg_we == 0 && reg_re == 0 && wake_pend == 0, "R1", miso_en, 0);

        // R2/R5: awake write sweep over every address
        p0 = wp_total;
        for (int a = 0; a < 128; a++) begin
            logic [7:0] d;
            d = 8'((a * 37 + 11) & 8'hFF);
            w0 = we_total;
            frame(16, {16'h0, 1'b0, 7'(a), d}, rd);
            chk(we_total == w0 + 1, "R2", we_total - w0, 1);
            chk(we_addr == 7'(a) && we_data == d, "R2", {we_addr, we_data}, {7'(a), d});
        end
        chk(wp_total == p0, "R5", wp_total - p0, 0);

        // R3: awake read sweep
        for (int a = 0; a < 128; a++) begin
            r0 = re_total; w0 = we_total;
            frame(16, {16'h0, 1'b1, 7'(a), 8'h00}, rd);
            chk(rd == (({7'(a), 1'b0}) ^ 8'hA5), "R3", rd, ({7'(a), 1'b0}) ^ 8'hA5);
            chk(re_total == r0 + 1 && we_total == w0, "R3", re_total - r0, 1);
        end

        // R10: output enable follows chip select when awake
        cs_drive(0);
        wait_cyc(4);
        chk(miso_en == 1, "R10", miso_en, 1);
        cs_drive(1);
        wait_cyc(4);
        chk(miso_en == 0, "R10", miso_en, 0);

        // R4: short frame writes nothing; long frame writes once
        w0 = we_total;
        frame(12, {20'h0, 1'b0, 7'h12, 4'hF}, rd);
        chk(we_total == w0, "R4", we_total - w0, 0);
        w0 = we_total;
        frame(24, {8'h0, 1'b0, 7'h33, 8'h5A, 8'hFF}, rd);
        chk(we_total == w0 + 1 && we_addr == 7'h33 && we_data == 8'h5A, "R4", we_total - w0, 1);

        // R6/R7: sleep with supply, early edges ignored, then full-rate frame
        sleep_mode = 1; vio = 1;
        w0 = we_total; p0 = wp_total;
        @(negedge clk); #5; csn = 0; t0 = cyc;
        #HALF;
        spi_bits(16, {16'h0, 1'b0, 7'h0F, 8'hF0}, rd);
        chk(miso_en == 0 && wake_pend == 1, "R6", miso_en, 0);
        wait (cyc >= t0 + WAKE - 30);
        @(negedge clk); #5;
        sclk = 1; #HALF; sclk = 0;
        wait (cyc >= t0 + WAKE + 10);
        @(negedge clk);
        chk(wake_pend == 0 && miso_en == 1, "R7", miso_en, 1);
        #5;
        spi_bits(16, {16'h0, 1'b0, 7'h55, 8'hC3}, rd);
        cs_drive(1);
        wait_cyc(8);
        chk(wp_total - p0 == WAKE, "R6", wp_total - p0, WAKE);
        chk(we_total == w0 + 1 && we_addr == 7'h55 && we_data == 8'hC3, "R7", {we_addr, we_data}, {7'h55, 8'hC3});

        // R8: abort during window, then a new full window
        w0 = we_total; p0 = wp_total;
        cs_drive(0);
        wait_cyc(100);
        chk(wake_pend == 1, "R8", wake_pend, 1);
        cs_drive(1);
        wait_cyc(6);
        chk(wake_pend == 0 && we_total == w0, "R8", wake_pend, 0);
        p0 = wp_total;
        @(negedge clk); #5; csn = 0; t0 = cyc;
        wait (cyc >= t0 + WAKE + 10);
        @(negedge clk); #5;
        spi_bits(16, {16'h0, 1'b0, 7'h2A, 8'h81}, rd);
        cs_drive(1);
        wait_cyc(8);
        chk(wp_total - p0 == WAKE, "R8", wp_total - p0, WAKE);
        chk(we_total == w0 + 1 && we_addr == 7'h2A && we_data == 8'h81, "R8", we_total - w0, 1);

        // R9: sleep without the I/O supply accepts nothing
        vio = 0;
        w0 = we_total; r0 = re_total; p0 = wp_total;
        cs_drive(0);
        wait_cyc(WAKE + 50);
        chk(miso_en == 0 && wake_pend == 0, "R9", miso_en, 0);
        #5;
        spi_bits(16, {16'h0, 1'b0, 7'h11, 8'h22}, rd);
        spi_bits(16, {16'h0, 1'b1, 7'h11, 8'h00}, rd);
        cs_drive(1);
        wait_cyc(8);
        chk(we_total == w0 && re_total == r0 && wp_total == p0, "R9", we_total - w0, 0);

        // R11: strobe widths seen over the whole run
        chk(viol == 0, "R11", viol, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule